// File: doc/BRIEF.md
# Smart Card Character Receiver with Parity Error Counting

This block takes the asynchronous I/O line of a smart card and turns it into host-readable bytes. It finds the falling edge of a start bit. It confirms the start at mid-bit, then samples eight data bits and a parity bit, one Elementary Time Unit (ETU) apart. It checks even parity and converts inverse-convention characters to direct convention. Characters with correct parity go into a receive FIFO whose usable depth is chosen at run time.

Characters with bad parity are never stored. Each one produces a one-cycle error pulse, which a NAK generator elsewhere can use. Under the T=0 protocol, a counter of consecutive parity errors is compared with a 3-bit limit, and the sticky parity-error flag rises only when the count reaches the limit plus one. Under T=1, every bad character raises the flag directly. The host reads the oldest byte at `rd_data_o` and removes it with `rd_en_i`.

Top module: `sc_rx_top`

## Requirements
- R1: The synchronized line is sampled 0.5 ETU after a falling edge, and then once per ETU after that. A low pulse that is already high again at the mid-start sample is discarded, and no character is received.
- R2: With `conv_inv_i`=0, a line-high bit is a logical 1 and the first data bit received is bit 0. A character is good when the 8 data bits and the parity bit (the ninth bit on the line) together hold an even number of ones.
- R3: With `conv_inv_i`=1, a line-low bit is a logical 1 and the first data bit received is bit 7. Parity is checked on the logical values. The stored byte is in direct convention.
- R4: Good characters are stored in arrival order. `rd_data_o` always shows the oldest stored byte, and a cycle with `rd_en_i`=1 removes it.
- R5: The FIFO holds `depth_sel_i`+1 bytes (1 to 8). A good character that arrives while the FIFO is full is dropped, and `overrun_o` goes to 1 and stays there until reset.
- R6: The FIFO is empty after reset and whenever `depth_sel_i` changes value. `not_empty_o` is 1 exactly when at least one byte is stored, and `rd_data_o` is 0 while the FIFO is empty.
- R7: With `proto_t1_i`=0, `parity_err_o` becomes 1 once `err_limit_i`+1 consecutive bad characters have been received. A limit of 0 therefore needs one bad character and a limit of 7 needs eight. The flag stays at 1 until reset.
- R8: With `proto_t1_i`=0, a good character received before the flag is set returns the consecutive-error count to zero.
- R9: With `proto_t1_i`=1, any bad character sets `parity_err_o`, whatever the value of `err_limit_i`.
- R10: A character with bad parity is not stored, and it produces exactly one single-cycle pulse on `perr_pulse_o`.
- R11: `rd_en_i` has no effect while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_line_i | input | 1 | Card I/O line (asynchronous) |
| conv_inv_i | input | 1 | 1 = inverse convention |
| proto_t1_i | input | 1 | 1 = T=1 error handling, 0 = T=0 counting |
| err_limit_i | input | 3 | T=0 parity error limit |
| depth_sel_i | input | 3 | FIFO depth minus one |
| rd_en_i | input | 1 | Pop the oldest byte |
| rd_data_o | output | 8 | Oldest stored byte |
| not_empty_o | output | 1 | At least one byte stored |
| parity_err_o | output | 1 | Sticky parity error flag |
| overrun_o | output | 1 | Sticky overrun flag |
| perr_pulse_o | output | 1 | One-cycle pulse per bad character |

## Verification
The hardest case to reach from the ports is the T=0 counter just below its limit, followed by a good character that has to clear it. Nothing exposes the count. The stimulus therefore sends limit-many bad frames, checks that the flag is still low, sends one good frame, and then sends limit-many bad frames again. The flag must stay low until one further bad frame arrives. Overrun is reached by selecting a two-entry FIFO and sending three good frames with no reads, which also shows that the first two bytes survive in order.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  // Returns {parity, data} in logical direct-convention order.
  function automatic logic [8:0] sc_to_direct(input logic [8:0] raw, input logic inv);
    logic [8:0] res;
    res = raw;
    if (inv) begin
      for (int i = 0; i < 8; i++) res[7-i] = ~raw[i];
      res[8] = ~raw[8];
    end
    return res;
  endfunction

endpackage

// File: rtl/sc_rx_sampler.sv
module sc_rx_sampler
  import sc_rx_pkg::*;
#(
  parameter int ETU_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic       valid_o,
  output logic [8:0] raw_o
);
  localparam int TW   = $clog2(ETU_CYCLES + 1);
  localparam int HALF = ETU_CYCLES / 2;
  localparam logic [TW-1:0] T_FULL = TW'(ETU_CYCLES - 1);
  localparam logic [TW-1:0] T_HALF = TW'(HALF - 1);

  logic      sync1_q, sync2_q, prev_q;
  rx_state_t st_q, st_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic [3:0] idx_q, idx_n;
  logic [8:0] raw_q, raw_n;
  logic       vld_q, vld_n;
  logic       fall;

  assign fall = prev_q & ~sync2_q;

  always_comb begin
    st_n  = st_q;
    tmr_n = tmr_q;
    idx_n = idx_q;
    raw_n = raw_q;
    vld_n = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_n  = RX_START;
          tmr_n = T_HALF;
        end
      end
      RX_START: begin
        if (tmr_q == '0) begin
          if (!sync2_q) begin
            st_n  = RX_BITS;
            tmr_n = T_FULL;
            idx_n = '0;
          end else begin
            st_n = RX_IDLE;
          end
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      RX_BITS: begin
        if (tmr_q == '0) begin
          raw_n[idx_q] = sync2_q;
          if (idx_q == 4'd8) begin
            vld_n = 1'b1;
            st_n  = RX_IDLE;
          end else begin
            idx_n = idx_q + 1'b1;
            tmr_n = T_FULL;
          end
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
      st_q    <= RX_IDLE;
      tmr_q   <= '0;
      idx_q   <= '0;
      raw_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      st_q    <= st_n;
      tmr_q   <= tmr_n;
      idx_q   <= idx_n;
      raw_q   <= raw_n;
      vld_q   <= vld_n;
    end
  end

  assign valid_o = vld_q;
  assign raw_o   = raw_q;

  // R1: a start that is high again at mid-start is abandoned
  p_false_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && tmr_q == '0 && sync2_q) |=> (st_q == RX_IDLE && !vld_q));
  // R10: each character produces a single valid pulse
  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/sc_rx_errcnt.sv
module sc_rx_errcnt #(
  parameter int LIMIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               char_vld_i,
  input  logic               par_ok_i,
  input  logic               proto_t1_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               flag_o,
  output logic               pulse_o
);
  localparam int CW = LIMIT_W + 1;
  localparam logic [CW-1:0] CMAX = CW'(1 << LIMIT_W);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          flag_q, flag_n;
  logic          pulse_q, pulse_n;

  always_comb begin
    cnt_n   = cnt_q;
    flag_n  = flag_q;
    pulse_n = char_vld_i & ~par_ok_i;
    if (char_vld_i) begin
      if (par_ok_i) begin
        cnt_n = '0;
      end else if (proto_t1_i) begin
        cnt_n  = '0;
        flag_n = 1'b1;
      end else begin
        cnt_n = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
        if (cnt_n >= ({1'b0, limit_i} + CW'(1))) flag_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      flag_q  <= flag_n;
      pulse_q <= pulse_n;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;

  // R7: the flag is sticky
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
  // R8: a good character clears the consecutive count
  p_good_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld_i && par_ok_i) |=> (cnt_q == '0));
  // R9: in T=1 any bad character raises the flag
  p_t1_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld_i && !par_ok_i && proto_t1_i) |=> flag_q);

endmodule

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
  parameter int DATA_W    = 8,
  parameter int DEPTH_MAX = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         rd_en_i,
  input  logic [$clog2(DEPTH_MAX)-1:0] depth_sel_i,
  output logic [DATA_W-1:0]            rd_data_o,
  output logic                         not_empty_o,
  output logic                         overrun_o
);
  localparam int PW = $clog2(DEPTH_MAX);
  localparam int CW = $clog2(DEPTH_MAX + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH_MAX - 1);

  logic [DATA_W-1:0] mem_q [DEPTH_MAX];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n, cap;
  logic [PW-1:0] sel_q;
  logic          ovr_q, ovr_n;
  logic          flush, full, do_wr, do_rd;

  assign cap   = CW'(sel_q) + CW'(1);
  assign full  = (cnt_q == cap);
  assign flush = (depth_sel_i != sel_q);
  assign do_wr = wr_en_i & ~full & ~flush;
  assign do_rd = rd_en_i & (cnt_q != '0) & ~flush;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    ovr_n = ovr_q | (wr_en_i & full & ~flush);
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_wr) wp_n = (wp_q == PLAST) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_n = (rp_q == PLAST) ? '0 : rp_q + 1'b1;
      if (do_wr && !do_rd) cnt_n = cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      sel_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      sel_q <= depth_sel_i;
      ovr_q <= ovr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wr_data_i;
  end

  assign not_empty_o = (cnt_q != '0);
  assign rd_data_o   = not_empty_o ? mem_q[rp_q] : '0;
  assign overrun_o   = ovr_q;

  // R5: occupancy never exceeds the selected capacity
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cap);
  // R5: overrun is sticky
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
  // R6: a depth change empties the FIFO
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  // R11: a read of an empty FIFO leaves it empty unless a write lands
  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && cnt_q == '0 && !wr_en_i) |=> (cnt_q == '0));

endmodule

// File: rtl/sc_rx_top.sv
module sc_rx_top
  import sc_rx_pkg::*;
#(
  parameter int ETU_CYCLES = 16,
  parameter int DEPTH_MAX  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_line_i,
  input  logic       conv_inv_i,
  input  logic       proto_t1_i,
  input  logic [2:0] err_limit_i,
  input  logic [2:0] depth_sel_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  output logic       not_empty_o,
  output logic       parity_err_o,
  output logic       overrun_o,
  output logic       perr_pulse_o
);
  logic       chr_vld;
  logic [8:0] chr_raw;
  logic [8:0] chr_dir;
  logic       par_ok;

  sc_rx_sampler #(.ETU_CYCLES(ETU_CYCLES)) u_smp (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (io_line_i),
    .valid_o (chr_vld),
    .raw_o   (chr_raw)
  );

  assign chr_dir = sc_to_direct(chr_raw, conv_inv_i);
  assign par_ok  = ~(^chr_dir);

  sc_rx_errcnt #(.LIMIT_W(3)) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_vld_i (chr_vld),
    .par_ok_i   (par_ok),
    .proto_t1_i (proto_t1_i),
    .limit_i    (err_limit_i),
    .flag_o     (parity_err_o),
    .pulse_o    (perr_pulse_o)
  );

  sc_rx_fifo #(.DATA_W(8), .DEPTH_MAX(DEPTH_MAX)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (chr_vld & par_ok),
    .wr_data_i   (chr_dir[7:0]),
    .rd_en_i     (rd_en_i),
    .depth_sel_i (depth_sel_i),
    .rd_data_o   (rd_data_o),
    .not_empty_o (not_empty_o),
    .overrun_o   (overrun_o)
  );

  // R10: a bad character never enters the FIFO
  p_bad_not_stored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_vld && !par_ok && !not_empty_o) |=> !not_empty_o);

endmodule

// File: tb/sc_rx_top_tb_top.sv
module sc_rx_top_tb_top;
  localparam int ETU = 16;

  logic clk, rst_n, io_line, conv_inv, proto_t1, rd_en;
  logic [2:0] err_limit, depth_sel;
  logic [7:0] rd_data;
  logic not_empty, parity_err, overrun, perr_pulse;

  int errors = 0;
  int checks = 0;
  int pulse_cnt = 0;
  logic [7:0] exp_q[$];
  int model_cnt = 0;
  int model_cap = 8;
  bit done = 0;

  sc_rx_top #(.ETU_CYCLES(ETU), .DEPTH_MAX(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_line_i(io_line), .conv_inv_i(conv_inv),
    .proto_t1_i(proto_t1), .err_limit_i(err_limit), .depth_sel_i(depth_sel),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .not_empty_o(not_empty),
    .parity_err_o(parity_err), .overrun_o(overrun), .perr_pulse_o(perr_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) if (perr_pulse) pulse_cnt <= pulse_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] dsel);
    rst_n = 1'b0; io_line = 1'b1; rd_en = 1'b0; depth_sel = dsel;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    exp_q.delete(); model_cnt = 0; model_cap = int'(dsel) + 1;
  endtask

  task automatic drive_bit(input logic b);
    io_line = b;
    repeat (ETU) @(posedge clk);
    #1;
  endtask

  // Send one frame; bad=1 corrupts parity. Good frames feed the scoreboard.
  task automatic send_char(input logic [7:0] d, input bit bad);
    logic [8:0] raw;
    logic p;
    p = (^d) ^ bad;
    for (int i = 0; i < 8; i++) raw[i] = conv_inv ? ~d[7-i] : d[i];
    raw[8] = conv_inv ? ~p : p;
    @(posedge clk); #1;
    drive_bit(1'b0);
    for (int i = 0; i < 9; i++) drive_bit(raw[i]);
    drive_bit(1'b1);
    drive_bit(1'b1);
    if (!bad) begin
      if (model_cnt < model_cap) begin
        exp_q.push_back(d); model_cnt++;
      end
    end
  endtask

  task automatic read_one(output logic [7:0] v);
    @(negedge clk);
    v = rd_data;
    rd_en = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  // Monitor: pop each produced byte and compare with the scoreboard
  task automatic drain(input string req);
    logic [7:0] v, e;
    @(negedge clk);
    while (not_empty) begin
      read_one(v);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      check(v === e, req, v, e);
      @(negedge clk);
    end
    check(exp_q.size() == 0, {req, " count"}, exp_q.size(), 0);
    model_cnt = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int p0;
    conv_inv = 0; proto_t1 = 0; err_limit = 3'd0;
    do_reset(3'd7);
    @(negedge clk);
    // R6: reset state
    check(!not_empty, "R6 reset empty", not_empty, 0);
    check(rd_data == 8'h00, "R6 reset data", rd_data, 0);
    check(!parity_err && !overrun, "R6 reset flags", {parity_err, overrun}, 0);

    // R2 / R4: direct convention, ordering
    send_char(8'hA5, 0); send_char(8'h3C, 0); send_char(8'h01, 0);
    drain("R2 R4 direct");

    // R3: inverse convention
    conv_inv = 1;
    send_char(8'h3B, 0); send_char(8'hC4, 0);
    drain("R3 inverse");
    conv_inv = 0;

    // R1: short low glitch rejected
    @(posedge clk); #1 io_line = 1'b0;
    repeat (ETU/4) @(posedge clk);
    #1 io_line = 1'b1;
    repeat (ETU*12) @(posedge clk);
    @(negedge clk);
    check(!not_empty, "R1 glitch ignored", not_empty, 0);

    // R11: read on empty has no effect
    read_one(v);
    read_one(v);
    send_char(8'h5A, 0);
    @(negedge clk);
    check(not_empty, "R11 after empty reads", not_empty, 1);
    drain("R11 data");

    // R5: depth 2, overrun
    do_reset(3'd1);
    send_char(8'h11, 0); send_char(8'h22, 0); send_char(8'h33, 0);
    @(negedge clk);
    check(overrun, "R5 overrun set", overrun, 1);
    drain("R5 kept");
    @(negedge clk);
    check(overrun, "R5 overrun sticky", overrun, 1);

    // R6: depth change flushes
    do_reset(3'd7);
    send_char(8'h44, 0); send_char(8'h55, 0);
    @(posedge clk); #1 depth_sel = 3'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!not_empty, "R6 flush", not_empty, 1'b0);
    exp_q.delete(); model_cnt = 0; model_cap = 4;

    // R7 / R8 / R10: T=0 limit 2
    do_reset(3'd7);
    err_limit = 3'd2;
    p0 = pulse_cnt;
    send_char(8'h12, 1); send_char(8'h34, 1);
    @(negedge clk);
    check(!parity_err, "R7 below limit", parity_err, 0);
    check(pulse_cnt - p0 == 2, "R10 pulses", pulse_cnt - p0, 2);
    check(!not_empty, "R10 bad not stored", not_empty, 0);
    send_char(8'h9E, 0);
    send_char(8'h12, 1); send_char(8'h34, 1);
    @(negedge clk);
    check(!parity_err, "R8 count reset by good", parity_err, 0);
    send_char(8'h56, 1);
    @(negedge clk);
    check(parity_err, "R7 limit reached", parity_err, 1);
    drain("R8 good stored");

    // R7: limit 0 needs a single error
    do_reset(3'd7);
    err_limit = 3'd0;
    send_char(8'h77, 1);
    @(negedge clk);
    check(parity_err, "R7 limit0", parity_err, 1);

    // R9: T=1 ignores the limit
    do_reset(3'd7);
    proto_t1 = 1; err_limit = 3'd7;
    send_char(8'h0F, 1);
    @(negedge clk);
    check(parity_err, "R9 t1 flag", parity_err, 1);
    check(!not_empty, "R10 t1 bad not stored", not_empty, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule